// File: doc/BRIEF.md
# I2C Slave Receiver with Selectable Clock-Stretch Points

This block receives bytes as an I2C slave. It synchronises the sampled SCL and SDA lines and finds START and STOP conditions. It shifts in an address byte and then data bytes, and compares the address byte with one or three programmable slave address registers. On a match it acknowledges the address. After that it receives data bytes until a STOP or a repeated START. When no register matches, the block stays off the bus until the next START.

Software sets where the block stretches the clock. There are two hold flags, and the block pulls SCL low while either of them is 0. A hold flag is cleared at the falling edge of the ACK clock, and an optional second one is cleared at the falling edge of the eighth data clock. The second point lets software look at the received byte and then choose ACK or NACK before the ACK clock starts. Each point where hardware stretches the clock gives a one-cycle interrupt pulse. Software releases the clock through strobe bits in a command register. A write-only STOP-flag clear and a software hold request are in the same register.

Top module: `i2c_stretch_rx`

## Requirements
- R1: The received byte holds the 7-bit address and the R/W bit, compared as a full 8-bit value (R/W = 0 for write). With MODE bit1 = 0, only SADR0 (reg 4) is compared. On a match, SDA is pulled low during the following ACK clock. STATUS bit3 (address matched) and STATUS bit4 (SADR0 matched) are set.
- R2: With MODE bit1 = 1, SADR0, SADR1 and SADR2 (regs 4, 5, 6) are all compared. A match sets STATUS bit3 and the per-register flag of each register that matched, in STATUS bits 4, 5 and 6. With MODE bit1 = 0, a byte that equals only SADR1 or SADR2 is not acknowledged.
- R3: When no register matches, the block does not drive SDA and does not stretch SCL. It ignores the data bytes that follow until the next START, so RXDATA (reg 3) does not change.
- R4: At the falling edge of the ACK clock of each acknowledged byte, the hold flag PIN (STATUS bit0) goes to 0. SCL is then held low and irq_o pulses for one cycle.
- R5: With MODE bit0 = 1 and MODE bit2 = 1, at the falling edge of the eighth clock of a data byte the hold flag PIN2 (STATUS bit1) goes to 0. SCL is then held low, irq_o pulses and RXDATA holds the byte.
- R6: MODE bit3 is the level driven during the ACK clock of a data byte when MODE bit2 = 1 (0 pulls SDA low for ACK, 1 leaves it released for NACK). A value written while SCL is held at the pre-ACK point is the value used in the ACK clock that follows.
- R7: scl_low_o is 1 whenever PIN or PIN2 is 0. It goes back to 0 only after a CMD write that leaves both flags at 1.
- R8: In CMD (reg 1), writing bit3 = 1 sets PIN to 1, writing bit0 = 1 sets PIN2 to 1 and writing bit1 = 1 clears PIN2 (SCL held low). Zero bits have no effect. When bit1 and bit0 are both 1, PIN2 ends at 0.
- R9: A STOP sets STATUS bit2 and returns the receiver to idle. Writing CMD bit2 = 1 clears that flag, and writing CMD bit2 = 0 leaves it set.
- R10: CMD reads as 0x00. MODE bits 7:4 read as 0, whatever was written.
- R11: A repeated START clears STATUS bits 3 to 6 and starts a new address phase, and the next byte is compared as an address.
- R12: After reset, STATUS = 0x03, MODE = 0x00, and scl_low_o, sda_low_o and irq_o are 0.
- R13: With MODE bit2 = 0, SDA is released during the ACK clock of a data byte, but the R4 hold still happens. Address bytes are acknowledged in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register index (0 MODE, 1 CMD, 2 STATUS, 3 RXDATA, 4..6 SADR0..2) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered, one cycle after cpu_addr |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low (open drain) |
| sda_low_o | output | 1 | 1 pulls SDA low (open drain) |
| irq_o | output | 1 | One-cycle pulse at each hardware hold point |

## Verification
The bench models a master that waits while the slave holds SCL low, so an unreleased hold appears as a hang that the bench reports. It writes the ACK level during the pre-ACK hold. A design that sampled that level too early would send the stale ACK where the new NACK was expected. It sends an address that equals only SADR2 with the three-register compare off. A block that ignored MODE bit1 would acknowledge it, stretch the clock and overwrite RXDATA with the following byte. It also writes the PIN2 set and hold bits together, issues repeated STARTs and writes zero strobes. Wrong priority leaves SCL released, and stale match flags or a STOP flag cleared by a zero write show up in STATUS.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SAR0 = 3'd4;
  // mode register fields
  localparam int MODE_W   = 4;
  localparam int M_EARLY  = 0;
  localparam int M_MULTI  = 1;
  localparam int M_ACKEN  = 2;
  localparam int M_ACKVAL = 3;
  // command strobes
  localparam int C_REL2    = 0;
  localparam int C_HOLD    = 1;
  localparam int C_STOPCLR = 2;
  localparam int C_REL     = 3;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_ACK, ST_SKIP} rx_state_e;
endpackage

// File: rtl/i2c_stretch_linesync.sv
module i2c_stretch_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh    <= '1;
      sda_sh    <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_bit   <= 1'b1;
    end else begin
      scl_sh    <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh    <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p     <= scl_s;
      sda_p     <= sda_s;
      scl_rise  <= scl_s & ~scl_p;
      scl_fall  <= ~scl_s & scl_p;
      start_det <= scl_s & scl_p & sda_p & ~sda_s;
      stop_det  <= scl_s & scl_p & ~sda_p & sda_s;
      sda_bit   <= sda_s;
    end
  end
endmodule

// File: rtl/i2c_stretch_addr_cmp.sv
module i2c_stretch_addr_cmp #(
  parameter int DATA_W  = 8,
  parameter int NUM_SAR = 3
) (
  input  logic [DATA_W-1:0]              rx_byte,
  input  logic [NUM_SAR-1:0][DATA_W-1:0] sar,
  input  logic                           multi_en,
  output logic [NUM_SAR-1:0]             hits
);
  for (genvar i = 0; i < NUM_SAR; i++) begin : g_cmp
    if (i == 0) begin : g_primary
      assign hits[i] = (rx_byte == sar[i]);
    end else begin : g_extra
      assign hits[i] = multi_en && (rx_byte == sar[i]);
    end
  end
endmodule

// File: rtl/i2c_stretch_engine.sv
module i2c_stretch_engine
  import i2c_stretch_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SAR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_bit,
  input  logic               early_en,
  input  logic               ack_en,
  input  logic               ack_val,
  input  logic [NUM_SAR-1:0] hits,
  output logic [DATA_W-1:0]  shreg,
  output logic               addr_ev,
  output logic               data_ev,
  output logic               hold_pre_ev,
  output logic               hold_post_ev,
  output logic               sda_low_o
);
  localparam int CW = $clog2(DATA_W + 1);

  rx_state_e   state;
  logic [CW-1:0] cnt;
  logic        is_addr;
  logic        ack_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      is_addr      <= 1'b0;
      ack_addr     <= 1'b0;
      sda_low_o    <= 1'b0;
      addr_ev      <= 1'b0;
      data_ev      <= 1'b0;
      hold_pre_ev  <= 1'b0;
      hold_post_ev <= 1'b0;
    end else begin
      addr_ev      <= 1'b0;
      data_ev      <= 1'b0;
      hold_pre_ev  <= 1'b0;
      hold_post_ev <= 1'b0;
      if (stop_det) begin
        state     <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else if (start_det) begin
        state     <= ST_SHIFT;
        cnt       <= '0;
        is_addr   <= 1'b1;
        sda_low_o <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (scl_rise && cnt < CW'(DATA_W)) begin
              shreg <= {shreg[DATA_W-2:0], sda_bit};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(DATA_W)) begin
              cnt <= '0;
              if (is_addr) begin
                addr_ev <= 1'b1;
                if (|hits) begin
                  state     <= ST_ACK;
                  ack_addr  <= 1'b1;
                  sda_low_o <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                data_ev     <= 1'b1;
                state       <= ST_ACK;
                ack_addr    <= 1'b0;
                sda_low_o   <= ack_en & ~ack_val;
                hold_pre_ev <= early_en & ack_en;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state        <= ST_SHIFT;
              is_addr      <= 1'b0;
              sda_low_o    <= 1'b0;
              hold_post_ev <= 1'b1;
            end else if (!ack_addr) begin
              // follows late writes of the ACK level during a pre-ACK hold
              sda_low_o <= ack_en & ~ack_val;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: an unmatched transfer leaves both lines alone
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_low_o && !hold_post_ev && !hold_pre_ev));
  // R9: STOP always returns to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE));
  // R11: START restarts the address phase
  p_start_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (state == ST_SHIFT && is_addr && cnt == '0));
endmodule

// File: rtl/i2c_stretch_regs.sv
module i2c_stretch_regs
  import i2c_stretch_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SAR = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cpu_we,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  output logic [DATA_W-1:0]              cpu_rdata,
  output logic [MODE_W-1:0]              mode_o,
  output logic [NUM_SAR-1:0][DATA_W-1:0] sar_o,
  input  logic                           addr_ev,
  input  logic [NUM_SAR-1:0]             hits,
  input  logic                           data_ev,
  input  logic [DATA_W-1:0]              rx_byte,
  input  logic                           hold_pre_ev,
  input  logic                           hold_post_ev,
  input  logic                           start_det,
  input  logic                           stop_det,
  output logic                           scl_low_o,
  output logic                           irq_o
);
  localparam int MATCH_LSB = 4;

  logic pin, pin2, stop_flag, aas;
  logic [NUM_SAR-1:0] match;
  logic [DATA_W-1:0]  rxd;
  logic [DATA_W-1:0]  stat;
  logic [DATA_W-1:0]  rd_mux;
  logic               cmd_wr;

  assign cmd_wr    = cpu_we && (cpu_addr == A_CMD);
  assign scl_low_o = ~(pin & pin2);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= '0;
      pin       <= 1'b1;
      pin2      <= 1'b1;
      stop_flag <= 1'b0;
      aas       <= 1'b0;
      match     <= '0;
      rxd       <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= hold_pre_ev | hold_post_ev;
      if (cpu_we && cpu_addr == A_MODE) mode_o <= cpu_wdata[MODE_W-1:0];
      if (hold_post_ev)                      pin <= 1'b0;
      else if (cmd_wr && cpu_wdata[C_REL])   pin <= 1'b1;
      if (hold_pre_ev)                       pin2 <= 1'b0;
      else if (cmd_wr && cpu_wdata[C_HOLD])  pin2 <= 1'b0;
      else if (cmd_wr && cpu_wdata[C_REL2])  pin2 <= 1'b1;
      if (stop_det)                             stop_flag <= 1'b1;
      else if (cmd_wr && cpu_wdata[C_STOPCLR])  stop_flag <= 1'b0;
      if (start_det) begin
        aas   <= 1'b0;
        match <= '0;
      end else if (addr_ev) begin
        aas   <= |hits;
        match <= hits;
      end
      if (data_ev) rxd <= rx_byte;
    end
  end

  for (genvar i = 0; i < NUM_SAR; i++) begin : g_sar
    always_ff @(posedge clk) begin
      if (rst) sar_o[i] <= '0;
      else if (cpu_we && cpu_addr == A_SAR0 + ADDR_W'(i)) sar_o[i] <= cpu_wdata;
    end
  end

  always_comb begin
    stat    = '0;
    stat[0] = pin;
    stat[1] = pin2;
    stat[2] = stop_flag;
    stat[3] = aas;
    for (int i = 0; i < NUM_SAR; i++) stat[MATCH_LSB + i] = match[i];
  end

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      A_MODE: rd_mux = {{(DATA_W-MODE_W){1'b0}}, mode_o};
      A_CMD:  rd_mux = '0;
      A_STAT: rd_mux = stat;
      A_RXD:  rd_mux = rxd;
      default: begin
        for (int i = 0; i < NUM_SAR; i++)
          if (cpu_addr == A_SAR0 + ADDR_W'(i)) rd_mux = sar_o[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_mux;
  end

  // R4: only the post-ACK event clears PIN
  p_pin_hw_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pin) |-> $past(hold_post_ev));
  // R8: PIN2 falls only from the pre-ACK event or a hold request
  p_pin2_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pin2) |-> $past(hold_pre_ev || (cmd_wr && cpu_wdata[C_HOLD])));
  // R5: interrupt is a single-cycle pulse
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R9: STOP sets the flag
  p_stop_flag_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> stop_flag);
  // R7: SCL is let go only by software
  p_release_sw_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_low_o) |-> $past(cmd_wr));
endmodule

// File: rtl/i2c_stretch_rx.sv
module i2c_stretch_rx
  import i2c_stretch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_SAR     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              irq_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic addr_ev, data_ev, hold_pre_ev, hold_post_ev;
  logic [NUM_SAR-1:0]             hits;
  logic [NUM_SAR-1:0][DATA_W-1:0] sar;
  logic [MODE_W-1:0]              mode;
  logic [DATA_W-1:0]              shreg;

  i2c_stretch_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
  );

  i2c_stretch_addr_cmp #(.DATA_W(DATA_W), .NUM_SAR(NUM_SAR)) u_cmp (
    .rx_byte(shreg), .sar(sar), .multi_en(mode[M_MULTI]), .hits(hits)
  );

  i2c_stretch_engine #(.DATA_W(DATA_W), .NUM_SAR(NUM_SAR)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .early_en(mode[M_EARLY]), .ack_en(mode[M_ACKEN]), .ack_val(mode[M_ACKVAL]),
    .hits(hits), .shreg(shreg),
    .addr_ev(addr_ev), .data_ev(data_ev),
    .hold_pre_ev(hold_pre_ev), .hold_post_ev(hold_post_ev),
    .sda_low_o(sda_low_o)
  );

  i2c_stretch_regs #(.DATA_W(DATA_W), .NUM_SAR(NUM_SAR)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mode_o(mode), .sar_o(sar),
    .addr_ev(addr_ev), .hits(hits), .data_ev(data_ev), .rx_byte(shreg),
    .hold_pre_ev(hold_pre_ev), .hold_post_ev(hold_post_ev),
    .start_det(start_det), .stop_det(stop_det),
    .scl_low_o(scl_low_o), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_i2c_stretch_rx.sv
module tb_i2c_stretch_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 1'b0;
  logic [2:0] cpu_addr = 3'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_low_o, sda_low_o, irq_o;
  logic       scl_line, sda_line;
  int         checks = 0, errors = 0, irq_cnt = 0;

  assign scl_line = scl_m & ~scl_low_o;
  assign sda_line = sda_m & ~sda_low_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stretch_rx dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .irq_o(irq_o)
  );

  always @(posedge clk) if (!rst && irq_o) irq_cnt <= irq_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    tick(2);
    d = cpu_rdata;
  endtask

  task automatic wait_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; wait_high(); tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
  endtask

  task automatic m_ack(output logic a);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    a = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_high(); tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    cpu_rd(3'd2, v); chk("R12 status", v, 8'h03);
    cpu_rd(3'd0, v); chk("R12 mode", v, 8'h00);
    chk("R12 scl_low", scl_low_o, 0);
    chk("R12 sda_low", sda_low_o, 0);
    chk("R12 irq", irq_cnt, 0);
  endtask

  task automatic t_single();
    logic [7:0] v; logic a; int i0;
    cpu_wr(3'd4, 8'hA0);
    cpu_wr(3'd0, 8'h04);
    m_start(); m_byte(8'hA0);
    chk("R4 no hold before ACK clock", scl_low_o, 0);
    i0 = irq_cnt;
    m_ack(a); chk("R1 address ACK", a, 0);
    tick(Q);
    chk("R4 SCL held after ACK", scl_low_o, 1);
    chk("R4 irq pulse", irq_cnt - i0, 1);
    cpu_rd(3'd2, v); chk("R1 status match0", v, 8'h1A);
    cpu_wr(3'd1, 8'h08); tick(2);
    chk("R7 SCL released", scl_low_o, 0);
    m_byte(8'h5A); m_ack(a); chk("R6 data ACK level 0", a, 0);
    tick(Q);
    chk("R4 data post hold", scl_low_o, 1);
    cpu_rd(3'd3, v); chk("R4 rxdata", v, 8'h5A);
    cpu_wr(3'd1, 8'h08);
    m_stop(); tick(Q);
    cpu_rd(3'd2, v); chk("R9 stop flag set", v[2], 1);
    cpu_wr(3'd1, 8'h00);
    cpu_rd(3'd2, v); chk("R9 zero write keeps flag", v[2], 1);
    cpu_wr(3'd1, 8'h04);
    cpu_rd(3'd2, v); chk("R9 flag cleared", v[2], 0);
  endtask

  task automatic t_nomatch();
    logic [7:0] v; logic a; int i0;
    cpu_wr(3'd0, 8'h04);
    cpu_wr(3'd6, 8'hB4);
    i0 = irq_cnt;
    m_start(); m_byte(8'hB4); m_ack(a);
    chk("R2 SADR2 ignored in single mode", a, 1);
    tick(Q);
    chk("R3 no stretch on miss", scl_low_o, 0);
    m_byte(8'h33); m_ack(a);
    chk("R3 data not acked", a, 1);
    tick(Q);
    chk("R3 no irq", irq_cnt - i0, 0);
    cpu_rd(3'd3, v); chk("R3 rxdata unchanged", v, 8'h5A);
    m_stop(); tick(Q);
    cpu_rd(3'd2, v); chk("R3 status", v, 8'h07);
    cpu_wr(3'd1, 8'h04);
  endtask

  task automatic t_three();
    logic [7:0] v; logic a;
    cpu_wr(3'd0, 8'h06);
    cpu_wr(3'd5, 8'h70);
    m_start(); m_byte(8'hB4); m_ack(a);
    chk("R2 SADR2 acked", a, 0);
    tick(Q);
    cpu_rd(3'd2, v); chk("R2 status match2", v, 8'h4A);
    cpu_wr(3'd1, 8'h08);
    m_start(); tick(2);
    cpu_rd(3'd2, v); chk("R11 flags cleared by repeated START", v, 8'h03);
    m_byte(8'h70); m_ack(a);
    chk("R11 new address acked", a, 0);
    tick(Q);
    cpu_rd(3'd2, v); chk("R2 status match1", v, 8'h2A);
    cpu_wr(3'd1, 8'h08);
    m_stop(); tick(Q);
    cpu_wr(3'd1, 8'h04);
  endtask

  task automatic t_early();
    logic [7:0] v; logic a; int i0;
    cpu_wr(3'd0, 8'h05);
    m_start(); m_byte(8'hA0); m_ack(a); tick(Q);
    chk("R1 ack in early mode", a, 0);
    cpu_wr(3'd1, 8'h08);
    i0 = irq_cnt;
    m_byte(8'hC3); tick(2);
    chk("R5 SCL held before ACK clock", scl_low_o, 1);
    chk("R5 irq at pre point", irq_cnt - i0, 1);
    cpu_rd(3'd2, v); chk("R5 PIN2 cleared", v, 8'h19);
    cpu_rd(3'd3, v); chk("R5 rxdata at pre point", v, 8'hC3);
    cpu_wr(3'd0, 8'h0D);
    cpu_wr(3'd1, 8'h01); tick(2);
    chk("R7 released after PIN2 set", scl_low_o, 0);
    m_ack(a); chk("R6 late NACK driven", a, 1);
    tick(Q);
    chk("R4 post hold after pre", irq_cnt - i0, 2);
    cpu_rd(3'd2, v); chk("R4 PIN cleared", v, 8'h1A);
    cpu_wr(3'd1, 8'h08);
    m_byte(8'h3C); tick(2);
    chk("R5 second pre hold", scl_low_o, 1);
    cpu_wr(3'd0, 8'h05);
    cpu_wr(3'd1, 8'h01);
    m_ack(a); chk("R6 late ACK driven", a, 0);
    tick(Q);
    cpu_wr(3'd1, 8'h08);
    m_stop(); tick(Q);
    cpu_wr(3'd1, 8'h04);
  endtask

  task automatic t_cmd();
    logic [7:0] v;
    cpu_wr(3'd1, 8'h02); tick(1);
    chk("R8 hold request", scl_low_o, 1);
    cpu_wr(3'd1, 8'h00);
    cpu_rd(3'd2, v); chk("R8 zero write no effect", v[1], 0);
    cpu_rd(3'd1, v); chk("R10 CMD reads 0", v, 8'h00);
    cpu_wr(3'd1, 8'h03);
    cpu_rd(3'd2, v); chk("R8 hold wins over set", v[1], 0);
    cpu_wr(3'd1, 8'h08); tick(1);
    chk("R7 still held with PIN2=0", scl_low_o, 1);
    cpu_wr(3'd1, 8'h01); tick(1);
    chk("R8 PIN2 set releases", scl_low_o, 0);
    cpu_wr(3'd0, 8'hFF);
    cpu_rd(3'd0, v); chk("R10 unused mode bits", v, 8'h0F);
    cpu_wr(3'd0, 8'h00);
  endtask

  task automatic t_noackclk();
    logic [7:0] v; logic a; int i0;
    cpu_wr(3'd0, 8'h00);
    m_start(); m_byte(8'hA0); m_ack(a);
    chk("R13 address still acked", a, 0);
    tick(Q);
    cpu_wr(3'd1, 8'h08);
    i0 = irq_cnt;
    m_byte(8'h81); m_ack(a);
    chk("R13 data not acked", a, 1);
    tick(Q);
    chk("R13 post hold kept", scl_low_o, 1);
    chk("R13 irq", irq_cnt - i0, 1);
    cpu_rd(3'd3, v); chk("R13 rxdata", v, 8'h81);
    cpu_wr(3'd1, 8'h08);
    m_stop(); tick(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_single();
    t_nomatch();
    t_three();
    t_early();
    t_cmd();
    t_noackclk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule